// File: doc/BRIEF.md
# Serial Memory Slave Front End with Pause

This block is the serial edge of a memory-style SPI slave. It oversamples the serial clock, the active-low select, the serial input and an active-low pause input with a fast system clock. It assembles the bits it receives into bytes and presents them to a command layer as one-cycle strobes. When the command layer offers a byte for return, the block shifts it out on the serial output and raises an output-enable, so that an outside pad can tri-state the line.

The first byte of each select period is the opcode. When the opcode is not in the recognised set, the rest of that select period is dropped. The pause input freezes the transfer at the exact bit it has reached. A pause can begin or end only while the serial clock is low. While paused, the serial output is released and clock and data activity on the link is discarded. Raising the select at any time ends the transfer and returns the block to idle. The synchronous reset stands for power-on.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data on `si` is taken on each rising `sck` edge, MSB first. After every 8 bits, `rx_valid` pulses for one `clk` cycle and `rx_byte` holds the assembled byte.
- R2: The byte that completes first after `cs_n` falls is flagged with `rx_first`=1. Every later byte in that select period carries `rx_first`=0.
- R3: Recognised opcodes are 0x01, 0x02, 0x03, 0x04, 0x05 and 0x06. For any other first byte, no strobe is produced for that byte or for any later byte, and `so_oe` stays 0 until `cs_n` rises.
- R4: At each byte boundary where `tx_en` is 1, the first falling `sck` edge after a complete byte loads `tx_data`. That byte then appears on `so`, MSB first, one bit per falling edge, with `so_oe`=1.
- R5: `so_oe` is 0 after reset, whenever `cs_n` is high, and while no return byte has been loaded (`tx_en` 0 at the boundary).
- R6: A pause begins only when `hold_n` is low while `sck` is low. A low `hold_n` during a high `sck` takes effect at the next low `sck`.
- R7: A pause ends only when `hold_n` is high while `sck` is low. A rise of `hold_n` during a high `sck` keeps the link paused.
- R8: While paused, `so_oe` is 0 and `sck` and `si` activity is discarded. After the pause, the byte continues from the bit where it stopped.
- R9: A rise of `cs_n` aborts the transfer, clears any pause and discards any partial byte. The next select period starts at bit 0.
- R10: The `sck` level when `cs_n` falls selects clock mode (0,0) or (1,1) and is shown on `clk_mode` (1 for mode (1,1)). Both modes produce identical byte strobes.
- R11: Reset clears the strobes, the output enable and `clk_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause request |
| tx_data | input | 8 | Byte to return, sampled at a byte boundary |
| tx_en | input | 1 | Return `tx_data` in the next byte |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so` |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last received byte |
| rx_first | output | 1 | Strobed byte is the opcode |
| clk_mode | output | 1 | Clock mode latched at select fall |

## Verification
A bit counter that moves during a pause shows up in the next strobe: the received byte comes out rotated, or the strobe arrives a whole byte late. A pause flag stuck at the wrong value shows up within one `sck` half period, either as `so_oe` still high after the pause has taken effect or as a byte that never completes. If the opcode filter or the abort-on-select fails, a strobe or an enabled output appears inside the same select period. Every input passes through the synchronisers and the edge detector, so each effect shows at the ports three to four `clk` cycles after the `sck` edge that causes it.

// File: rtl/spihf_pkg.sv
package spihf_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WR   = 8'h02;
  localparam logic [BYTE_W-1:0] OP_RD   = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;

  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    return (op == OP_WRSR) || (op == OP_WR) || (op == OP_RD) ||
           (op == OP_WRDI) || (op == OP_RDSR) || (op == OP_WREN);
  endfunction
endpackage

// File: rtl/spihf_sync.sv
module spihf_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[g] <= RST_VAL;
          else     st[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) st[g] <= RST_VAL;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/spihf_hold_ctl.sv
module spihf_hold_ctl (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic paused
);
  always_ff @(posedge clk) begin
    if (rst || !active) paused <= 1'b0;
    else if (!sck_s)    paused <= !hold_n_s;
  end

  // R6: a pause only starts after a cycle with sck low and hold low
  a_r6_enter_sck_low: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> (!$past(sck_s) && !$past(hold_n_s)));
  // R7: a pause only ends with sck low, or through deselect
  a_r7_exit_sck_low: assert property (@(posedge clk) disable iff (rst)
    $fell(paused) |-> (!$past(sck_s) || !$past(active)));
  // R9: deselect clears the pause
  a_r9_cs_clears_pause: assert property (@(posedge clk) disable iff (rst)
    !active |=> !paused);
endmodule

// File: rtl/spihf_shifter.sv
module spihf_shifter
  import spihf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              cs_fall,
  input  logic              sck_s,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              si_s,
  input  logic              paused,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  output logic              so_bit,
  output logic              oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_first,
  output logic              cpol
);
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_q;
  logic              op_done;
  logic              ignore;
  logic              rise_g, fall_g;
  logic [BYTE_W-1:0] next_byte;
  logic [BIT_CW-1:0] out_idx;

  assign rise_g    = rise_ev && active && !paused && !ignore;
  assign fall_g    = fall_ev && active && !paused && !ignore;
  assign next_byte = {rx_sh, si_s};
  assign out_idx   = BIT_CW'(BYTE_W - 1) - bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) cpol <= 1'b0;
    else if (cs_fall) cpol <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
    end else if (rise_g && bit_cnt == BIT_CW'(BYTE_W - 1)) begin
      rx_byte <= next_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_q     <= '0;
      op_done  <= 1'b0;
      ignore   <= 1'b0;
      oe       <= 1'b0;
      so_bit   <= 1'b0;
      rx_valid <= 1'b0;
      rx_first <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_g) begin
        rx_sh   <= next_byte[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_CW'(BYTE_W - 1)) begin
          if (!op_done) begin
            op_done <= 1'b1;
            if (op_known(next_byte)) begin
              rx_valid <= 1'b1;
              rx_first <= 1'b1;
            end else begin
              ignore <= 1'b1;
            end
          end else begin
            rx_valid <= 1'b1;
            rx_first <= 1'b0;
          end
        end
      end
      if (fall_g) begin
        if (bit_cnt == '0) begin
          if (op_done) begin
            tx_q   <= tx_data;
            oe     <= tx_en;
            so_bit <= tx_data[BYTE_W-1];
          end
        end else begin
          so_bit <= tx_q[out_idx];
        end
      end
    end
  end

  // R8: the bit position is frozen while paused
  a_r8_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (active && $past(paused && active)) |-> $stable(bit_cnt));
  // R3: an ignored select period produces no strobes
  a_r3_no_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
    ignore |-> !rx_valid);
  // R9: deselect returns the shifter to bit 0 with output off
  a_r9_cs_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> (bit_cnt == '0 && !oe && !rx_valid));
  // R1: strobes last a single cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spihf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  output logic              so,
  output logic              so_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_first,
  output logic              clk_mode
);
  localparam int NSIG = 4;
  // bit order: {hold_n, si, cs_n, sck}
  localparam logic [NSIG-1:0] SYNC_RST = 4'b1010;

  logic [NSIG-1:0] raw, syn;
  logic sck_s, cs_s, si_s, hold_s;
  logic sck_q, cs_q;
  logic active, cs_fall, rise_ev, fall_ev;
  logic paused;
  logic sh_so, sh_oe;

  assign raw = {hold_n, si, cs_n, sck};

  spihf_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign sck_s  = syn[0];
  assign cs_s   = syn[1];
  assign si_s   = syn[2];
  assign hold_s = syn[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign active  = !cs_s;
  assign cs_fall = !cs_s && cs_q;
  assign rise_ev = sck_s && !sck_q;
  assign fall_ev = !sck_s && sck_q;

  spihf_hold_ctl u_hold (
    .clk(clk), .rst(rst), .active(active), .sck_s(sck_s),
    .hold_n_s(hold_s), .paused(paused)
  );

  spihf_shifter u_shift (
    .clk(clk), .rst(rst), .active(active), .cs_fall(cs_fall),
    .sck_s(sck_s), .rise_ev(rise_ev), .fall_ev(fall_ev), .si_s(si_s),
    .paused(paused), .tx_data(tx_data), .tx_en(tx_en),
    .so_bit(sh_so), .oe(sh_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_first(rx_first), .cpol(clk_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      so    <= sh_so;
      so_oe <= sh_oe && !paused && active;
    end
  end

  // R8: output released while paused
  a_r8_oe_off_paused: assert property (@(posedge clk) disable iff (rst)
    paused |=> !so_oe);
  // R5: output released while deselected
  a_r5_oe_off_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe);
endmodule

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;
  localparam int H = 8;

  logic clk = 0;
  logic rst = 1;
  logic sck = 0, cs_n = 1, si = 0, hold_n = 1;
  logic [7:0] tx_data = 8'h00;
  logic tx_en = 0;
  logic so, so_oe, rx_valid, rx_first, clk_mode;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_fail = 0;
  int n_strobe = 0;
  int n_oe_hi = 0;
  logic [7:0] cap_byte [16];
  logic       cap_first [16];

  always #5 clk = ~clk;

  spi_hold_frontend u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .tx_data(tx_data), .tx_en(tx_en), .so(so), .so_oe(so_oe),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_first(rx_first),
    .clk_mode(clk_mode)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (n_strobe < 16) begin
        cap_byte[n_strobe]  <= rx_byte;
        cap_first[n_strobe] <= rx_first;
      end
      n_strobe <= n_strobe + 1;
    end
    if (!rst && so_oe) n_oe_hi <= n_oe_hi + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b);
    sck = 0; si = b; wait_h();
    sck = 1; wait_h();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_cycle(v[i]);
  endtask

  task automatic select(input logic idle_lvl);
    sck = idle_lvl; wait_h();
    cs_n = 0; wait_h();
    n_strobe = 0; n_oe_hi = 0;
  endtask

  task automatic deselect();
    wait_h(); cs_n = 1; sck = 0; tx_en = 0; hold_n = 1; wait_h(); wait_h();
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    chk("R11 so_oe", so_oe, 0);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 clk_mode", clk_mode, 0);
  endtask

  task automatic t_mode0();
    select(0);
    chk("R10 mode0", clk_mode, 0);
    send_byte(8'h02); send_byte(8'h3C); send_byte(8'hA1);
    wait_h();
    chk("R1 count", n_strobe, 3);
    chk("R2 first flag op", cap_first[0], 1);
    chk("R1 op byte", cap_byte[0], 8'h02);
    chk("R1 byte1", cap_byte[1], 8'h3C);
    chk("R2 first flag data", cap_first[1], 0);
    chk("R1 byte2", cap_byte[2], 8'hA1);
    chk("R5 no read oe", n_oe_hi, 0);
    deselect();
    chk("R5 deselected oe", so_oe, 0);
  endtask

  task automatic t_mode3();
    select(1);
    chk("R10 mode3", clk_mode, 1);
    send_byte(8'h06); send_byte(8'h7E);
    wait_h();
    chk("R10 count", n_strobe, 2);
    chk("R10 op byte", cap_byte[0], 8'h06);
    chk("R10 first flag", cap_first[0], 1);
    chk("R10 data byte", cap_byte[1], 8'h7E);
    deselect();
  endtask

  task automatic t_read();
    logic [7:0] got;
    int oe_ok;
    got = 0; oe_ok = 1;
    select(0);
    send_byte(8'h03); send_byte(8'h10);
    tx_data = 8'hA5; tx_en = 1;
    for (int i = 7; i >= 0; i--) begin
      sck = 0; si = 0; wait_h();
      got[i] = so;
      if (!so_oe) oe_ok = 0;
      sck = 1; wait_h();
    end
    chk("R4 read data", got, 8'hA5);
    chk("R4 oe during read", oe_ok, 1);
    deselect();
    chk("R5 oe after deselect", so_oe, 0);
  endtask

  task automatic t_bad_op();
    select(0);
    tx_data = 8'h33; tx_en = 1;
    send_byte(8'hFF); send_byte(8'h12); send_byte(8'h03);
    wait_h();
    chk("R3 no strobes", n_strobe, 0);
    chk("R3 oe never on", n_oe_hi, 0);
    deselect();
  endtask

  task automatic t_hold_mid();
    int s0;
    select(0);
    send_byte(8'h02);
    bit_cycle(0); bit_cycle(1); bit_cycle(0); bit_cycle(1);
    sck = 0; wait_h();
    hold_n = 0; wait_h();
    s0 = n_strobe;
    for (int k = 0; k < 5; k++) begin
      si = ~si; sck = 1; wait_h(); sck = 0; wait_h();
    end
    chk("R8 no strobe in pause", n_strobe, s0);
    chk("R8 oe off in pause", so_oe, 0);
    hold_n = 1; wait_h();
    bit_cycle(1); bit_cycle(1); bit_cycle(0); bit_cycle(0);
    wait_h();
    chk("R8 strobes after resume", n_strobe, 2);
    chk("R8 resumed byte", cap_byte[1], 8'h5C);
    deselect();
  endtask

  task automatic t_hold_qual();
    select(0);
    send_byte(8'h03);
    tx_data = 8'hF0; tx_en = 1;
    bit_cycle(0); bit_cycle(0);
    hold_n = 0; wait_h();
    chk("R6 no pause with sck high", so_oe, 1);
    sck = 0; wait_h();
    chk("R6 pause once sck low", so_oe, 0);
    sck = 1; wait_h();
    hold_n = 1; wait_h();
    chk("R7 still paused with sck high", so_oe, 0);
    sck = 0; wait_h();
    chk("R7 resume with sck low", so_oe, 1);
    deselect();
  endtask

  task automatic t_cs_abort();
    select(0);
    bit_cycle(1); bit_cycle(0); bit_cycle(1);
    hold_n = 0; sck = 0; wait_h();
    deselect();
    chk("R9 no strobe from partial", n_strobe, 0);
    select(0);
    send_byte(8'h06);
    wait_h();
    chk("R9 count after abort", n_strobe, 1);
    chk("R9 realigned byte", cap_byte[0], 8'h06);
    chk("R9 first flag", cap_first[0], 1);
    deselect();
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode3();
    t_read();
    t_bad_op();
    t_hold_mid();
    t_hold_qual();
    t_cs_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule